// File: doc/BRIEF.md
# Loop-Exit Branch Predictor

This block sits beside a general-purpose conditional branch predictor. It supplies an exact answer for one kind of branch: a loop-closing branch that is taken some fixed number of times and then falls through once. A predictor that always guesses taken, or one that keeps a short history, gets that fall-through wrong on every pass of the loop. This block counts the iterations of each loop branch it tracks, so once it knows the trip count it also predicts the exit iteration.

Resolved conditional branches come in on the update port, one per cycle at most. A branch that is not yet tracked goes through a single candidate tracker. The tracker counts a run of taken outcomes from one PC. When that PC then resolves not-taken after a long enough run, the block allocates an entry and records the run length as the trip count. A tracked branch advances its iteration counter on every taken outcome. On each exit it compares the iteration count with the stored trip count and adjusts its confidence.

The lookup port is combinational and fully associative on the full PC. It raises a hit flag only for a fully confident entry. The pipeline uses that flag to let this block's direction override the base predictor. For every other branch the block stays silent.

Top module: `loop_exit_pred`

## Requirements
- R1: After reset (`rst_ni` low) no entry is valid and `pred_hit_o` and `pred_taken_o` read 0 for any PC.
- R2: A not-taken update from a PC that is not in the table allocates an entry when it follows at least two taken updates from the same PC. Those taken updates must come with no taken update from a different untracked PC in between. The entry holds trip count = run length, iteration 0 and confidence 0. Not-taken updates from other untracked PCs do not break the run, and a PC is never held by two entries.
- R3: A run of zero or one taken outcome followed by not-taken allocates nothing, so that PC never produces a hit.
- R4: A taken update to a tracked PC adds one to its iteration count, which saturates at 2^CNT_W-1. A not-taken update (an exit) returns the count to 0.
- R5: On an exit whose iteration count equals the stored trip count, confidence rises by one and saturates at 3. On any other exit, confidence drops to 0 and the trip count is replaced by the observed iteration count.
- R6: `pred_hit_o` is 1 only when `pred_pc_i` matches a valid entry whose confidence is 3.
- R7: On a hit, `pred_taken_o` is 0 when the entry's iteration count equals its trip count and 1 otherwise. It is 0 whenever there is no hit. A loop that repeats one trip count, large counts included, is predicted exactly from its fifth pass, the exit iteration included.
- R8: Allocation uses a round-robin pointer over all entries, starting at entry 0 after reset. The ninth allocation evicts the first allocated entry.
- R9: The lookup uses the table state from before any update in the same cycle. A cycle with `upd_valid_i` low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pred_pc_i | input | PC_W | PC looked up this cycle |
| pred_hit_o | output | 1 | Confident entry found; override the base predictor |
| pred_taken_o | output | 1 | Predicted direction (1 = taken), valid with the hit |
| upd_valid_i | input | 1 | A resolved conditional branch is presented |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Resolved direction (1 = taken) |

## Verification
A corrupted trip count, iteration count or confidence value shows up only through the two prediction outputs. A confidence fault moves the first hit to an earlier or later pass of the loop. A counting fault stays hidden until the entry is confident, up to four loop passes later, and then shows as a wrong direction at or near the exit iteration. The bench therefore runs each loop shape for at least five passes and compares both outputs against a behavioural model on every cycle. It also queries PCs other than the one being updated, so that faults in the tag match or in replacement become visible.

// File: rtl/loop_pred_pkg.sv
package loop_pred_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_TAKEN = 2'd1,
    EV_EXIT  = 2'd2
  } lp_event_e;
endpackage

// File: rtl/lp_entry.sv
module lp_entry
  import loop_pred_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int CNT_W  = 16,
  parameter int CONF_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [PC_W-1:0]   alloc_pc_i,
  input  logic [CNT_W-1:0]  alloc_trip_i,
  input  lp_event_e         ev_i,
  output logic              valid_o,
  output logic [PC_W-1:0]   tag_o,
  output logic [CNT_W-1:0]  trip_o,
  output logic [CNT_W-1:0]  iter_o,
  output logic [CONF_W-1:0] conf_o
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [CONF_W-1:0] CONF_MAX = '1;

  logic              valid_q;
  logic [PC_W-1:0]   tag_q;
  logic [CNT_W-1:0]  trip_q, iter_q;
  logic [CONF_W-1:0] conf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      trip_q  <= '0;
      iter_q  <= '0;
      conf_q  <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      tag_q   <= alloc_pc_i;
      trip_q  <= alloc_trip_i;
      iter_q  <= '0;
      conf_q  <= '0;
    end else begin
      unique case (ev_i)
        EV_TAKEN: if (iter_q != CNT_MAX) iter_q <= iter_q + 1'b1;
        EV_EXIT: begin
          iter_q <= '0;
          if (iter_q == trip_q) begin
            if (conf_q != CONF_MAX) conf_q <= conf_q + 1'b1;
          end else begin
            conf_q <= '0;
            trip_q <= iter_q; // relearn
          end
        end
        default: ;
      endcase
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign trip_o  = trip_q;
  assign iter_o  = iter_q;
  assign conf_o  = conf_q;

  // R2
  alloc_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> valid_q && iter_q == '0 && conf_q == '0 && trip_q == $past(alloc_trip_i));

  // R4
  exit_clears_iter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_EXIT && !alloc_i) |=> iter_q == '0);

  // R5
  mismatch_drops_conf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_EXIT && !alloc_i && iter_q != trip_q) |=> conf_q == '0 && trip_q == $past(iter_q));

  // R5
  match_raises_conf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_EXIT && !alloc_i && iter_q == trip_q && conf_q != CONF_MAX)
      |=> conf_q == CONF_W'($past(conf_q) + 1'b1));

  // R2
  event_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != EV_NONE) |-> valid_q);
endmodule

// File: rtl/lp_cand.sv
module lp_cand #(
  parameter int PC_W  = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_valid_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic             upd_taken_i,
  input  logic             tbl_hit_i,
  output logic             alloc_o,
  output logic [CNT_W-1:0] alloc_trip_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] MIN_RUN = CNT_W'(2);

  logic [PC_W-1:0]  cand_pc_q;
  logic [CNT_W-1:0] run_q;
  logic             active, same;

  assign active       = upd_valid_i && !tbl_hit_i;
  assign same         = (run_q != '0) && (cand_pc_q == upd_pc_i);
  assign alloc_o      = active && !upd_taken_i && same && (run_q >= MIN_RUN);
  assign alloc_trip_o = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_pc_q <= '0;
      run_q     <= '0;
    end else if (active) begin
      if (upd_taken_i) begin
        if (same) begin
          if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
        end else begin
          cand_pc_q <= upd_pc_i;
          run_q     <= CNT_W'(1);
        end
      end else if (same) begin
        run_q <= '0;
      end
    end
  end

  // R3
  run_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && upd_taken_i && !same) |=> run_q == CNT_W'(1) && cand_pc_q == $past(upd_pc_i));

  // R2
  run_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !upd_taken_i && same) |=> run_q == '0);
endmodule

// File: rtl/lp_rr.sv
module lp_rr #(
  parameter int NUM_ENT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  output logic [NUM_ENT-1:0] victim_o
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENT - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (adv_i)   ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_dec
    assign victim_o[i] = (ptr_q == IDX_W'(i));
  end

  // R8
  victim_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(victim_o));

  // R8
  rr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(victim_o));
endmodule

// File: rtl/loop_exit_pred.sv
module loop_exit_pred
  import loop_pred_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int PC_W    = 32,
  parameter int CNT_W   = 16,
  parameter int CONF_W  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_hit_o,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam logic [CONF_W-1:0] CONF_MAX = '1;

  logic               ent_valid [NUM_ENT];
  logic [PC_W-1:0]    ent_tag   [NUM_ENT];
  logic [CNT_W-1:0]   ent_trip  [NUM_ENT];
  logic [CNT_W-1:0]   ent_iter  [NUM_ENT];
  logic [CONF_W-1:0]  ent_conf  [NUM_ENT];
  lp_event_e          ent_ev    [NUM_ENT];

  logic [NUM_ENT-1:0] pred_match, upd_match, victim, alloc_vec;
  logic               tbl_hit, alloc;
  logic [CNT_W-1:0]   alloc_trip;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    assign pred_match[i] = ent_valid[i] && (ent_tag[i] == pred_pc_i);
    assign upd_match[i]  = upd_valid_i && ent_valid[i] && (ent_tag[i] == upd_pc_i);
    assign ent_ev[i]     = !upd_match[i] ? EV_NONE : (upd_taken_i ? EV_TAKEN : EV_EXIT);
    assign alloc_vec[i]  = alloc && victim[i];

    lp_entry #(.PC_W(PC_W), .CNT_W(CNT_W), .CONF_W(CONF_W)) u_entry (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc_vec[i]),
      .alloc_pc_i  (upd_pc_i),
      .alloc_trip_i(alloc_trip),
      .ev_i        (ent_ev[i]),
      .valid_o     (ent_valid[i]),
      .tag_o       (ent_tag[i]),
      .trip_o      (ent_trip[i]),
      .iter_o      (ent_iter[i]),
      .conf_o      (ent_conf[i])
    );
  end

  assign tbl_hit = |upd_match;

  lp_cand #(.PC_W(PC_W), .CNT_W(CNT_W)) u_cand (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_valid_i (upd_valid_i),
    .upd_pc_i    (upd_pc_i),
    .upd_taken_i (upd_taken_i),
    .tbl_hit_i   (tbl_hit),
    .alloc_o     (alloc),
    .alloc_trip_o(alloc_trip)
  );

  lp_rr #(.NUM_ENT(NUM_ENT)) u_rr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (alloc),
    .victim_o(victim)
  );

  // lookup sees pre-update state
  always_comb begin
    pred_hit_o   = 1'b0;
    pred_taken_o = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (pred_match[i]) begin
        pred_hit_o   = (ent_conf[i] == CONF_MAX);
        pred_taken_o = (ent_conf[i] == CONF_MAX) && (ent_iter[i] != ent_trip[i]);
      end
    end
  end

  // R2
  upd_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(upd_match));

  // R6
  pred_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pred_match));

  // R7
  no_hit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_hit_o |-> !pred_taken_o);
endmodule

// File: tb/loop_exit_pred_tb.sv
module loop_exit_pred_tb;
  localparam int N      = 8;
  localparam int CMAX   = 65535;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0, upd_pc = '0;
  logic        upd_valid = 1'b0, upd_taken = 1'b0;
  logic        pred_hit, pred_taken;

  always #5 clk = ~clk;

  loop_exit_pred u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pred_pc_i   (pred_pc),
    .pred_hit_o  (pred_hit),
    .pred_taken_o(pred_taken),
    .upd_valid_i (upd_valid),
    .upd_pc_i    (upd_pc),
    .upd_taken_i (upd_taken)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural model
  bit          m_v    [N];
  logic [31:0] m_tag  [N];
  int          m_trip [N], m_iter [N], m_conf [N];
  int          m_rr = 0;
  logic [31:0] c_pc = '0;
  int          c_run = 0;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic model_pred(input logic [31:0] q, output bit h, output bit t);
    h = 0; t = 0;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_tag[i] == q) begin
        h = (m_conf[i] == 3);
        t = h && (m_iter[i] != m_trip[i]);
      end
  endtask

  task automatic model_upd(input bit v, input logic [31:0] pc, input bit tk);
    int hi;
    bit same;
    if (!v) return;
    hi = -1;
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == pc) hi = i;
    if (hi >= 0) begin
      if (tk) begin
        if (m_iter[hi] < CMAX) m_iter[hi]++;
      end else begin
        if (m_iter[hi] == m_trip[hi]) begin
          if (m_conf[hi] < 3) m_conf[hi]++;
        end else begin
          m_conf[hi] = 0;
          m_trip[hi] = m_iter[hi];
        end
        m_iter[hi] = 0;
      end
    end else begin
      same = (c_run != 0) && (c_pc == pc);
      if (tk) begin
        if (same) begin
          if (c_run < CMAX) c_run++;
        end else begin
          c_pc = pc;
          c_run = 1;
        end
      end else if (same) begin
        if (c_run >= 2) begin
          m_v[m_rr] = 1; m_tag[m_rr] = pc; m_trip[m_rr] = c_run;
          m_iter[m_rr] = 0; m_conf[m_rr] = 0;
          m_rr = (m_rr + 1) % N;
        end
        c_run = 0;
      end
    end
  endtask

  task automatic step(input bit v, input logic [31:0] pc, input bit tk, input logic [31:0] q,
                      input string req, input bit e_use = 0, input bit e_hit = 0, input bit e_tk = 0);
    bit mh, mt;
    @(negedge clk);
    upd_valid = v; upd_pc = pc; upd_taken = tk; pred_pc = q;
    #1;
    model_pred(q, mh, mt);
    chk(req, "hit vs model", pred_hit, mh);
    chk(req, "taken vs model", pred_taken, mt);
    if (e_use) begin
      chk(req, "hit expected", pred_hit, e_hit);
      chk(req, "taken expected", pred_taken, e_tk);
    end
    model_upd(v, pc, tk);
  endtask

  // one loop pass: trips taken then one exit; optional fixed expectation
  task automatic run_loop(input logic [31:0] pc, input int trips, input string req,
                          input bit e_use = 0, input bit e_hit = 0);
    for (int k = 0; k < trips; k++) step(1, pc, 1, pc, req, e_use, e_hit, e_hit);
    step(1, pc, 0, pc, req, e_use, e_hit, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_tag[i] = '0; m_trip[i] = 0; m_iter[i] = 0; m_conf[i] = 0;
    end
    // R1: reset state
    repeat (3) @(negedge clk);
    pred_pc = 32'h100; #1; chk("R1", "hit in reset", pred_hit, 1'b0);
    chk("R1", "taken in reset", pred_taken, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 32'h0, 0, 32'h0, "R1", 1, 0, 0);
    step(0, 32'h0, 0, 32'h100, "R1", 1, 0, 0);

    // R2 R5 R6: loop A trip 5, confident after pass 4 exit
    run_loop(32'h100, 5, "R2");
    run_loop(32'h100, 5, "R5");
    run_loop(32'h100, 5, "R5");
    run_loop(32'h100, 5, "R6", 1, 0);
    // R7: fifth pass exact
    run_loop(32'h100, 5, "R7", 1, 1);

    // R5: trip change 5 -> 7, confidence rebuilt
    for (int p = 0; p < 5; p++) run_loop(32'h100, 7, "R5");
    run_loop(32'h100, 7, "R7", 1, 1);

    // R9: idle cycles change nothing; lookup of other PCs
    for (int k = 0; k < 4; k++) step(0, 32'h100, 1, 32'h100, "R9", 1, 1, 1);
    step(1, 32'h100, 1, 32'h100, "R9", 1, 1, 1);
    step(0, 32'h0, 0, 32'h104, "R6", 1, 0, 0);
    for (int k = 0; k < 6; k++) step(1, 32'h100, 1, 32'h100, "R4");
    step(1, 32'h100, 0, 32'h100, "R4", 1, 1, 0);

    // R3: short runs never allocate
    for (int p = 0; p < 6; p++) begin
      step(1, 32'h200, 1, 32'h200, "R3");
      step(1, 32'h200, 0, 32'h200, "R3", 1, 0, 0);
      step(1, 32'h200, 0, 32'h200, "R3", 1, 0, 0);
    end

    // R2: taken from another untracked PC restarts the run
    for (int p = 0; p < 6; p++) begin
      step(1, 32'h500, 1, 32'h500, "R2");
      step(1, 32'h504, 1, 32'h500, "R2");
      step(1, 32'h500, 1, 32'h500, "R2");
      step(1, 32'h500, 0, 32'h500, "R2", 1, 0, 0);
    end

    // R2: loop B with interleaved not-taken branch that does not break the run
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 4; k++) begin
        step(1, 32'h400, 1, 32'h400, "R2");
        step(1, 32'h404, 0, 32'h400, "R2");
      end
      step(1, 32'h400, 0, 32'h400, "R2", p == 5, p == 5, 0);
    end

    // R7: large trip count
    for (int p = 0; p < 4; p++) run_loop(32'h300, 1000, "R7");
    run_loop(32'h300, 1000, "R7", 1, 1);

    // R8: A still confident, then eight new allocations evict A, B, large loop
    step(0, 32'h0, 0, 32'h100, "R8", 1, 1, 1);
    for (int j = 0; j < 8; j++) run_loop(32'h600 + 32'(16 * j), 2, "R8");
    step(0, 32'h0, 0, 32'h100, "R8", 1, 0, 0);
    step(0, 32'h0, 0, 32'h400, "R8", 1, 0, 0);
    step(0, 32'h0, 0, 32'h300, "R8", 1, 0, 0);
    for (int p = 0; p < 4; p++) run_loop(32'h670, 2, "R8");
    step(0, 32'h0, 0, 32'h670, "R8", 1, 1, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule